// File: doc/BRIEF.md
# Keyboard Make/Break Event Tracker

This block sits behind a keyboard frame receiver and turns its stream of received bytes into single key events. Press codes arrive as a bare key byte. Releases are announced by a break prefix (F0). Extended keys carry an extension prefix (E0), and an extended release carries both prefixes in the order E0, F0. The tracker folds each such sequence into one event that carries the key byte, an extended flag and a released flag.

While a key is held, the keyboard keeps resending its press code at the typematic rate. The tracker holds one held bit for each (extended, code) pair. A press for a key that is already held is marked as a repeat, so the host can tell a first press from auto-repeat. Acknowledge and echo replies (FA, EE) that the receiver passes along are dropped. A prefix that arrives where it cannot be legal aborts the sequence and raises an error pulse. Shift and other modifier keys are treated as ordinary keys. No character translation is done.

Top module: `kbd_event_tracker`

## Requirements
- R1: While reset is asserted and after its release, `evt_vld`, `proto_err` and every event field read 0, and every held bit is clear, so the first press of any key after reset has `evt_repeat` = 0.
- R2: A key byte (any value other than E0, F0, FA, EE) accepted with no prefix pending produces `evt_vld` for exactly one cycle, in the cycle after the byte is accepted, with `evt_code` = the byte, `evt_ext` = 0 and `evt_release` = 0.
- R3: The sequence E0 followed by a key byte produces one press event with `evt_ext` = 1.
- R4: The sequence F0 followed by a key byte produces one event with `evt_release` = 1 and `evt_ext` = 0.
- R5: The sequence E0, F0, key byte produces one event with `evt_release` = 1 and `evt_ext` = 1.
- R6: A press event has `evt_repeat` = 1 exactly when the same (extended, code) pair has been pressed and not released since reset. Extended and plain keys with the same code byte are tracked separately. A press on the cycle right after another press of the same key already reads as a repeat.
- R7: A release event always has `evt_repeat` = 0, is reported even when the key was not held, and clears that key's held bit.
- R8: Bytes FA and EE produce neither an event nor an error, in any parser state, and leave a pending prefix intact (E0, FA, key gives an extended press).
- R9: An out-of-place prefix (E0 after E0, E0 or F0 after F0, E0 or F0 after E0 F0) raises `proto_err` for one cycle, in the cycle after that byte, with no event. The pending sequence is dropped, so the next key byte is a plain press.
- R10: Cycles with `byte_vld` low have no effect, whatever `byte_data` holds.
- R11: A prefix byte accepted in a legal position produces neither an event nor an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a received byte |
| byte_data | input | 8 | Received keyboard byte |
| evt_vld | output | 1 | One-cycle key event strobe |
| evt_code | output | 8 | Key code of the event |
| evt_ext | output | 1 | Event belongs to an extended key |
| evt_release | output | 1 | 1 = key released, 0 = key pressed |
| evt_repeat | output | 1 | Press of a key that was already held |
| proto_err | output | 1 | One-cycle pulse on an out-of-place prefix |

## Verification
In a single cycle the held table is both looked up, for the repeat flag of the current event, and written, for the key state after that event. The risk is that back-to-back bytes for the same key read a stale or a forwarded value. The bench provokes this by sending press, press and release, press runs of one key on consecutive cycles with no idle gap, directed and inside a random stream of a few frequent codes. It judges each repeat flag against a bench model that updates its own held array only after it has computed that event's expectation.

// File: rtl/kbd_trk_pkg.sv
package kbd_trk_pkg;

  localparam int BYTE_W = 8;
  localparam int KEY_IDX_W = BYTE_W + 1;

  localparam logic [BYTE_W-1:0] PFX_EXT  = 8'hE0;
  localparam logic [BYTE_W-1:0] PFX_BRK  = 8'hF0;
  localparam logic [BYTE_W-1:0] ACK_OK   = 8'hFA;
  localparam logic [BYTE_W-1:0] ACK_ECHO = 8'hEE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAW_EXT,
    ST_SAW_BRK,
    ST_SAW_EXT_BRK
  } prs_state_e;

  typedef struct packed {
    logic              ext;
    logic              rel;
    logic [BYTE_W-1:0] code;
  } key_evt_t;

endpackage

// File: rtl/kbd_rst_sync.sv
module kbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/kbd_prefix_parser.sv
module kbd_prefix_parser
  import kbd_trk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              key_done,
  output key_evt_t          key_evt,
  output logic              seq_err
);

  prs_state_e state_q;
  prs_state_e state_d;
  logic       is_ext;
  logic       is_brk;
  logic       is_ack;

  assign is_ext = (byte_data == PFX_EXT);
  assign is_brk = (byte_data == PFX_BRK);
  assign is_ack = (byte_data == ACK_OK) || (byte_data == ACK_ECHO);

  always_comb begin
    state_d      = state_q;
    key_done     = 1'b0;
    seq_err      = 1'b0;
    key_evt.ext  = 1'b0;
    key_evt.rel  = 1'b0;
    key_evt.code = byte_data;
    if (byte_vld && !is_ack) begin
      case (state_q)
        ST_IDLE: begin
          if (is_ext)      state_d = ST_SAW_EXT;
          else if (is_brk) state_d = ST_SAW_BRK;
          else             key_done = 1'b1;
        end
        ST_SAW_EXT: begin
          if (is_ext) begin
            seq_err = 1'b1;
            state_d = ST_IDLE;
          end else if (is_brk) begin
            state_d = ST_SAW_EXT_BRK;
          end else begin
            key_done    = 1'b1;
            key_evt.ext = 1'b1;
            state_d     = ST_IDLE;
          end
        end
        ST_SAW_BRK: begin
          state_d = ST_IDLE;
          if (is_ext || is_brk) begin
            seq_err = 1'b1;
          end else begin
            key_done    = 1'b1;
            key_evt.rel = 1'b1;
          end
        end
        ST_SAW_EXT_BRK: begin
          state_d = ST_IDLE;
          if (is_ext || is_brk) begin
            seq_err = 1'b1;
          end else begin
            key_done    = 1'b1;
            key_evt.rel = 1'b1;
            key_evt.ext = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> (state_q == ST_IDLE));                                     // R2
  AST_ERR_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (state_q == ST_IDLE));                                      // R9
  AST_ACK_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && is_ack) |=> (state_q == $past(state_q)));                  // R8
  AST_IDLE_CYCLE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> (state_q == $past(state_q)));                             // R10

endmodule

// File: rtl/kbd_held_table.sv
module kbd_held_table #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             rel,
  input  logic [IDX_W-1:0] idx,
  output logic             held
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] held_q;
  logic [DEPTH-1:0] held_d;

  always_comb begin
    held_d      = held_q;
    held_d[idx] = !rel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '0;
    else if (upd) held_q <= held_d;
  end

  assign held = held_q[idx];

  AST_PRESS_MARKS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !rel) |=> held_q[$past(idx)]);                                  // R6
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && rel) |=> !held_q[$past(idx)]);                                  // R7
  AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(held_q ^ $past(held_q)) <= 1));                    // R6
  AST_NO_UPD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(held_q));                                              // R10

endmodule

// File: rtl/kbd_event_tracker.sv
module kbd_event_tracker
  import kbd_trk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              evt_vld,
  output logic [BYTE_W-1:0] evt_code,
  output logic              evt_ext,
  output logic              evt_release,
  output logic              evt_repeat,
  output logic              proto_err
);

  logic                 rst_n_s;
  logic                 key_done;
  key_evt_t             key_evt;
  logic                 seq_err;
  logic                 key_held;
  logic [KEY_IDX_W-1:0] key_idx;

  logic                 vld_d, vld_q;
  logic                 err_d, err_q;
  logic                 rep_d;
  key_evt_t             evt_q;
  logic                 rep_q;

  kbd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  kbd_prefix_parser u_parser (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .key_done  (key_done),
    .key_evt   (key_evt),
    .seq_err   (seq_err)
  );

  assign key_idx = {key_evt.ext, key_evt.code};

  kbd_held_table #(.IDX_W(KEY_IDX_W)) u_held (
    .clk   (clk),
    .rst_n (rst_n_s),
    .upd   (key_done),
    .rel   (key_evt.rel),
    .idx   (key_idx),
    .held  (key_held)
  );

  always_comb begin
    vld_d = key_done;
    err_d = seq_err;
    rep_d = key_held && !key_evt.rel;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      evt_q <= '0;
      rep_q <= 1'b0;
    end else if (key_done) begin
      evt_q <= key_evt;
      rep_q <= rep_d;
    end
  end

  assign evt_vld     = vld_q;
  assign proto_err   = err_q;
  assign evt_code    = evt_q.code;
  assign evt_ext     = evt_q.ext;
  assign evt_release = evt_q.rel;
  assign evt_repeat  = rep_q;

  AST_EVT_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n_s)
    evt_vld |-> $past(byte_vld));                                           // R10
  AST_EVT_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(evt_vld && proto_err));                                               // R9
  AST_RELEASE_NOT_REPEAT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (evt_vld && evt_release) |-> !evt_repeat);                              // R7
  AST_ACK_SILENT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (byte_vld && (byte_data == ACK_OK || byte_data == ACK_ECHO))
      |=> (!evt_vld && !proto_err));                                        // R8
  AST_EVT_CODE_IS_KEY: assert property (@(posedge clk) disable iff (!rst_n_s)
    evt_vld |-> (evt_code != PFX_EXT && evt_code != PFX_BRK));              // R2

endmodule

// File: tb/sim_kbd_event_tracker.sv
`timescale 1ns/1ps
module sim_kbd_event_tracker;

  logic       clk;
  logic       rst_n;
  logic       byte_vld;
  logic [7:0] byte_data;
  logic       evt_vld;
  logic [7:0] evt_code;
  logic       evt_ext;
  logic       evt_release;
  logic       evt_repeat;
  logic       proto_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  int       m_state;          // 0 idle, 1 saw E0, 2 saw F0, 3 saw E0 F0
  bit       m_held [512];
  bit       exp_vld, exp_err, exp_ext, exp_rel, exp_rep;
  bit [7:0] exp_code;
  string    exp_tag;

  kbd_event_tracker u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .byte_data   (byte_data),
    .evt_vld     (evt_vld),
    .evt_code    (evt_code),
    .evt_ext     (evt_ext),
    .evt_release (evt_release),
    .evt_repeat  (evt_repeat),
    .proto_err   (proto_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_pfx(input bit [7:0] b);
    return (b == 8'hE0) || (b == 8'hF0) || (b == 8'hFA) || (b == 8'hEE);
  endfunction

  task automatic model_reset();
    m_state = 0;
    for (int i = 0; i < 512; i++) m_held[i] = 1'b0;
    exp_vld = 0; exp_err = 0; exp_tag = "R1";
  endtask

  task automatic model_key(input bit ext, input bit rel, input bit [7:0] b, input string tag);
    int idx;
    idx      = {23'd0, ext, b};
    exp_vld  = 1;
    exp_code = b;
    exp_ext  = ext;
    exp_rel  = rel;
    exp_rep  = rel ? 1'b0 : m_held[idx];
    exp_tag  = (!rel && m_held[idx]) ? "R6" : tag;
    m_held[idx] = !rel;
    m_state  = 0;
  endtask

  task automatic model(input bit v, input bit [7:0] b);
    exp_vld = 0; exp_err = 0;
    if (!v) begin
      exp_tag = "R10";
    end else if (b == 8'hFA || b == 8'hEE) begin
      exp_tag = "R8";
    end else begin
      case (m_state)
        0: if (b == 8'hE0) begin m_state = 1; exp_tag = "R11"; end
           else if (b == 8'hF0) begin m_state = 2; exp_tag = "R11"; end
           else model_key(0, 0, b, "R2");
        1: if (b == 8'hE0) begin m_state = 0; exp_err = 1; exp_tag = "R9"; end
           else if (b == 8'hF0) begin m_state = 3; exp_tag = "R11"; end
           else model_key(1, 0, b, "R3");
        2: if (b == 8'hE0 || b == 8'hF0) begin m_state = 0; exp_err = 1; exp_tag = "R9"; end
           else model_key(0, 1, b, "R4");
        default: if (b == 8'hE0 || b == 8'hF0) begin m_state = 0; exp_err = 1; exp_tag = "R9"; end
           else model_key(1, 1, b, "R5");
      endcase
    end
  endtask

  task automatic check_outputs();
    chk(exp_tag, "evt_vld", int'(evt_vld), int'(exp_vld));
    chk(exp_tag, "proto_err", int'(proto_err), int'(exp_err));
    if (exp_vld) begin
      chk(exp_tag, "evt_code", int'(evt_code), int'(exp_code));
      chk(exp_tag, "evt_ext", int'(evt_ext), int'(exp_ext));
      chk(exp_tag, "evt_release", int'(evt_release), int'(exp_rel));
      chk(exp_rel ? "R7" : exp_tag, "evt_repeat", int'(evt_repeat), int'(exp_rep));
    end
  endtask

  // drive one cycle; first judge the outputs caused by the previous cycle
  task automatic step(input bit v, input bit [7:0] b);
    @(negedge clk);
    check_outputs();
    model(v, b);
    byte_vld  = v;
    byte_data = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    byte_vld = 0; byte_data = 8'h00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "evt_vld in reset", int'(evt_vld), 0);
    chk("R1", "proto_err in reset", int'(proto_err), 0);
    chk("R1", "evt_code in reset", int'(evt_code), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "evt_vld after reset", int'(evt_vld), 0);
    chk("R1", "evt_repeat after reset", int'(evt_repeat), 0);
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [7:0] pool [5];
    byte_vld = 0; byte_data = 8'h00; rst_n = 0;
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    // R2 / R6: first press, back-to-back repeat, release, fresh press
    step(1, 8'h1C);
    step(1, 8'h1C);          // R6 repeat seen on the very next cycle
    step(1, 8'hF0);
    step(1, 8'h1C);          // R4 release
    step(1, 8'h1C);          // R6 fresh press, no repeat
    // R3 / R6: extended key with same code byte is separate
    step(1, 8'hE0);
    step(1, 8'h1C);
    step(1, 8'hE0);
    step(1, 8'h1C);          // R6 extended repeat
    // R5 extended release, R7 release of unheld key
    step(1, 8'hE0); step(1, 8'hF0); step(1, 8'h1C);
    step(1, 8'hE0); step(1, 8'hF0); step(1, 8'h1C);
    step(1, 8'hF0); step(1, 8'h4B);
    // R8 acknowledges inside prefixes
    step(1, 8'hFA);
    step(1, 8'hE0); step(1, 8'hFA); step(1, 8'h75);
    step(1, 8'hF0); step(1, 8'hEE); step(1, 8'h75);
    step(1, 8'hE0); step(1, 8'hF0); step(1, 8'hEE); step(1, 8'h75);
    // R10 idle cycles with prefix garbage on the data bus
    step(0, 8'hF0); step(0, 8'hE0); step(0, 8'h33); step(1, 8'h33);
    // R9 out-of-place prefixes, then a plain press
    step(1, 8'hF0); step(1, 8'hF0); step(1, 8'h2A);
    step(1, 8'hF0); step(1, 8'hE0); step(1, 8'h2A);
    step(1, 8'hE0); step(1, 8'hE0); step(1, 8'h2A);
    step(1, 8'hE0); step(1, 8'hF0); step(1, 8'hE0); step(1, 8'h2A);
    step(1, 8'hE0); step(1, 8'hF0); step(1, 8'hF0); step(1, 8'h2A);
    step(0, 8'h00);

    // R1: held state cleared by reset (0x33 is held here)
    do_reset();
    step(1, 8'h33);
    step(0, 8'h00);

    // random stream over a few frequent codes
    pool[0] = 8'h12; pool[1] = 8'h1C; pool[2] = 8'h33; pool[3] = 8'h59; pool[4] = 8'h75;
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit [7:0] b;
      r = int'($urandom % 100);
      if (r < 25) begin
        step(0, 8'($urandom));
      end else if (r < 37) begin
        step(1, 8'hE0);
      end else if (r < 52) begin
        step(1, 8'hF0);
      end else if (r < 56) begin
        step(1, ($urandom % 2) ? 8'hFA : 8'hEE);
      end else if (r < 88) begin
        step(1, pool[$urandom % 5]);
      end else begin
        b = 8'($urandom);
        while (is_pfx(b)) b = 8'($urandom);
        step(1, b);
      end
    end
    step(0, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule